// File: doc/BRIEF.md
# Tube Warm-Up Switch-On Sequencer

This block brings a picture-tube drive path up in two stages after power-on. In the first stage the cathodes are still cold: the video is forced to ultra-black during line scan, and during every vertical blanking interval a white monitor pulse is requested so that cathode current can be measured. A digitised threshold flag from that measurement is sampled once per field, at the end of vertical blanking. Two consecutive fields above threshold end the first stage.

In the second stage the monitor pulse stops and cut-off regulation is enabled, while line-scan blanking stays on. Each field end also samples a per-channel "error inside tolerance" flag from the cut-off loops. Once all channels have stayed inside tolerance for a programmable number of consecutive fields, the sequencer enters its running state. There, blanking is released and cut-off control stays on. Only a supply-drop reset brings the sequencer back to the first stage.

Top module: `warmup_seq`

## Requirements
- R1: While `rst_ni` is low, and directly after it, the sequencer is in the warm-up stage: `cutoff_en_o` is 0, `blank_o` equals `line_i` and `monitor_o` equals `vblank_i`.
- R2: In the warm-up and settling stages `blank_o` follows `line_i` (1 during line scan). In the running stage `blank_o` is 0.
- R3: `monitor_o` is 1 only during vertical blanking (`vblank_i` = 1) and only in the warm-up stage.
- R4: A field end is the first clock edge at which `vblank_i` is sampled 0 after it was 1. `thr_i` and `in_band_i` have no effect at any other edge.
- R5: Leaving warm-up takes `HIT_COUNT` consecutive field ends (default 2) with `thr_i` = 1. A field end with `thr_i` = 0 restarts that count.
- R6: At the field end that completes R5, the stage becomes settling: `cutoff_en_o` rises to 1 and `monitor_o` stays 0 from then on.
- R7: Settling lasts until `STABLE_FIELDS` consecutive field ends (default 4) sample every bit of `in_band_i` as 1 (bit n = channel n inside tolerance). A field end with any bit at 0 restarts the count.
- R8: The running stage keeps `cutoff_en_o` at 1 and `blank_o` and `monitor_o` at 0, whatever the inputs do, until reset.
- R9: A low on `rst_ni` returns the sequencer to warm-up from any stage, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous supply-drop reset |
| vblank_i | input | 1 | Vertical blanking interval active |
| line_i | input | 1 | Active line scan |
| thr_i | input | 1 | Cathode current above warm-up threshold |
| in_band_i | input | CH | Per-channel cut-off error inside tolerance |
| blank_o | output | 1 | Force ultra-black during line scan |
| monitor_o | output | 1 | Inject white monitor pulse |
| cutoff_en_o | output | 1 | Enable cut-off regulation |

## Verification
The bench uses the default parameters, HIT_COUNT = 2 and STABLE_FIELDS = 4. With these values a single run of about fifteen fields covers a broken threshold run, a broken stability run, both stage changes and the running stage. Threshold and tolerance flags are driven high between field ends, so that an edge sampled in the wrong place would show up at the outputs. A final test applies reset in the running stage and checks that a single threshold hit is no longer enough to leave warm-up.

// File: rtl/warmup_pkg.sv
package warmup_pkg;
  typedef enum logic [1:0] {
    PH_WARM   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;
endpackage

// File: rtl/field_edge.sv
module field_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_i,
  output logic field_end_o
);
  logic vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_q <= 1'b0;
    else         vb_q <= vblank_i;
  end

  // end of blanking = measurement period closes
  assign field_end_o = vb_q & ~vblank_i;
endmodule

// File: rtl/consec_cnt.sv
module consec_cnt #(
  parameter int LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic hit_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (!hit_i)          cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = step_i & hit_i & (cnt_q == LAST);
endmodule

// File: rtl/warmup_seq.sv
module warmup_seq
  import warmup_pkg::*;
#(
  parameter int HIT_COUNT     = 2,
  parameter int STABLE_FIELDS = 4,
  parameter int CH            = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vblank_i,
  input  logic          line_i,
  input  logic          thr_i,
  input  logic [CH-1:0] in_band_i,
  output logic          blank_o,
  output logic          monitor_o,
  output logic          cutoff_en_o
);
  phase_e state_q, state_d;
  logic   field_end;
  logic   hit_done, stab_done;
  logic   all_in_band;

  field_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vblank_i   (vblank_i),
    .field_end_o(field_end)
  );

  assign all_in_band = &in_band_i;

  consec_cnt #(.LIMIT(HIT_COUNT)) u_hit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(field_end && state_q == PH_WARM),
    .hit_i (thr_i),
    .done_o(hit_done)
  );

  consec_cnt #(.LIMIT(STABLE_FIELDS)) u_stab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(field_end && state_q == PH_SETTLE),
    .hit_i (all_in_band),
    .done_o(stab_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_WARM:   if (hit_done)  state_d = PH_SETTLE;
      PH_SETTLE: if (stab_done) state_d = PH_RUN;
      PH_RUN:    state_d = PH_RUN;
      default:   state_d = PH_WARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_WARM;
    else         state_q <= state_d;
  end

  assign blank_o     = line_i & (state_q != PH_RUN);
  assign monitor_o   = vblank_i & (state_q == PH_WARM);
  assign cutoff_en_o = (state_q != PH_WARM);
endmodule

// File: rtl/warmup_seq_chk.sv
module warmup_seq_chk
  import warmup_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   vblank_i,
  input logic   line_i,
  input logic   blank_o,
  input logic   monitor_o,
  input logic   cutoff_en_o,
  input phase_e state_q
);
  logic vb_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_d <= 1'b0;
    else         vb_d <= vblank_i;
  end

  // R2
  blank_in_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> line_i);

  // R3
  monitor_in_vb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    monitor_o |-> (vblank_i && !cutoff_en_o));

  // R4
  edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vb_d && !vblank_i) |=> $stable(state_q));

  // R6
  cutoff_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cutoff_en_o |=> cutoff_en_o);

  // R8
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_RUN) |=> (state_q == PH_RUN && !blank_o && !monitor_o));
endmodule

bind warmup_seq warmup_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vblank_i   (vblank_i),
  .line_i     (line_i),
  .blank_o    (blank_o),
  .monitor_o  (monitor_o),
  .cutoff_en_o(cutoff_en_o),
  .state_q    (state_q)
);

// File: tb/tb_warmup_seq.sv
`timescale 1ns/1ps
module tb_warmup_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vblank_i = 1'b0;
  logic       line_i = 1'b0;
  logic       thr_i = 1'b0;
  logic [2:0] in_band_i = 3'b000;
  logic       blank_o, monitor_o, cutoff_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  warmup_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .vblank_i(vblank_i), .line_i(line_i),
    .thr_i(thr_i), .in_band_i(in_band_i),
    .blank_o(blank_o), .monitor_o(monitor_o), .cutoff_en_o(cutoff_en_o)
  );

  // {thr at field end, in_band at field end, exp cutoff_en, exp blank in scan}
  localparam logic [5:0] VEC [14] = '{
    {1'b0, 3'b000, 1'b0, 1'b1},  // warm, no hit
    {1'b1, 3'b000, 1'b0, 1'b1},  // R5 first hit
    {1'b0, 3'b000, 1'b0, 1'b1},  // R5 miss restarts
    {1'b1, 3'b000, 1'b0, 1'b1},  // R5 hit 1
    {1'b1, 3'b000, 1'b1, 1'b1},  // R6 hit 2 -> settle
    {1'b0, 3'b111, 1'b1, 1'b1},  // R7 1
    {1'b0, 3'b111, 1'b1, 1'b1},  // R7 2
    {1'b0, 3'b011, 1'b1, 1'b1},  // R7 one channel out restarts
    {1'b0, 3'b111, 1'b1, 1'b1},  // R7 1
    {1'b0, 3'b111, 1'b1, 1'b1},  // R7 2
    {1'b0, 3'b111, 1'b1, 1'b1},  // R7 3
    {1'b0, 3'b111, 1'b1, 1'b0},  // R7 4 -> run
    {1'b0, 3'b000, 1'b1, 1'b0},  // R8 holds
    {1'b1, 3'b000, 1'b1, 1'b0}   // R8 holds
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // noisy vblank, field end with given flags, line scan with noise
  task automatic field(input logic t, input logic [2:0] b);
    vblank_i = 1'b1; line_i = 1'b0; thr_i = 1'b1; in_band_i = 3'b111;  // R4 noise
    cyc(2);
    thr_i = t; in_band_i = b; vblank_i = 1'b0; line_i = 1'b1;
    cyc(1);
    thr_i = 1'b1; in_band_i = 3'b111;  // R4 noise outside field end
    cyc(2);
  endtask

  initial begin
    cyc(2);
    // R1 reset state
    line_i = 1'b1; #1;
    check("R1", cutoff_en_o, 1'b0);
    check("R1", blank_o, 1'b1);
    check("R1", monitor_o, 1'b0);
    vblank_i = 1'b1; line_i = 1'b0; #1;
    check("R1", monitor_o, 1'b1);
    cyc(1);
    rst_ni = 1'b1;
    cyc(1);

    for (int i = 0; i < 14; i++) begin
      field(VEC[i][5], VEC[i][4:2]);
      check("R5/R6/R7", cutoff_en_o, VEC[i][1]);
      check("R2", blank_o, VEC[i][0]);
      check("R3", monitor_o, 1'b0);
      vblank_i = 1'b1; line_i = 1'b0;
      cyc(1);
      check("R3", monitor_o, ~VEC[i][1]);
      check("R8", blank_o, 1'b0);
    end

    // R8: stay in run under any vblank/line activity
    line_i = 1'b1; vblank_i = 1'b0; thr_i = 1'b0; in_band_i = 3'b000;
    cyc(3);
    check("R8", blank_o, 1'b0);
    check("R8", cutoff_en_o, 1'b1);

    // R9 asynchronous return to warm-up
    #3 rst_ni = 1'b0; #1;
    check("R9", cutoff_en_o, 1'b0);
    check("R9", blank_o, 1'b1);
    cyc(1);
    rst_ni = 1'b1;
    cyc(1);
    field(1'b1, 3'b111);
    check("R9", cutoff_en_o, 1'b0);
    field(1'b1, 3'b111);
    check("R6", cutoff_en_o, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule